// File: doc/BRIEF.md
# Windowed Data-Memory Bus Slave

This block is a data-memory target on a 32-bit memory bus. It has two channels. A master sends requests on one. The slave returns responses on the other. Each channel has its own valid/ready pair. A request carries a byte address, a write flag, an access size, lane-aligned write data, four byte strobes and a four-bit atomic-op code. A response carries a 32-bit read word and one error bit.

The slave decodes a 64 KB window based at `0x8000_0000` and backs it with a single-port RAM. Byte strobes gate each write lane by lane. A read returns its data one cycle after the request is accepted. The slave also accepts requests that fall outside the window and answers them with the error bit set. The error bit stands only for faults the slave itself owns, such as an unmapped address. Alignment and access size belong to the requesting master and never raise it.

The slave takes one request, lowers its request ready while the response is pending, and holds the response steady until the master takes it.

Top module: `memslv_top`

## Requirements
- R1: A beat moves on a channel only in a cycle where that channel's valid and ready are both high. With `reqValid` low, no response appears. While a response is pending (`rspValid` high), `reqReady` is low.
- R2: A request accepted at clock edge N has `rspValid` high from edge N+1. For an in-window read, `rspData` then holds the addressed word.
- R3: While `rspValid` is high and `rspReady` is low, `rspValid`, `rspData` and `rspErr` stay unchanged into the next cycle. The response retires at the first edge where `rspReady` is high.
- R4: A write changes only the byte lanes whose strobe bit is set. Strobe bit k covers `reqWdata[8k+7:8k]` and byte address offset k of the word. For example, data `0x0000AB00` with strobes `0010` at `0x8000_0001` changes only that byte.
- R5: The window spans `0x8000_0000` to `0x8000_FFFF` inclusive. `0x8000_FFFC` is inside. `0x7FFF_FFFC` and `0x8001_0000` are outside.
- R6: A request outside the window is accepted and answered with `rspErr`=1 and `rspData`=0. It does not change the RAM, including the word its low address bits would alias to.
- R7: An in-window request never gets `rspErr`=1, whatever its alignment or size. The word index is `reqAddr[15:2]`. `reqAddr[1:0]` and `reqSize` (00 byte, 01 half, 10 word) do not change the result, and a read returns the whole word.
- R8: A nonzero `reqAmo` value has no effect. Reads and writes behave as they would with it at zero.
- R9: During and right after reset, `rspValid` is 0 and `reqReady` is 1.
- R10: A write response carries `rspErr`=0 when the address is in the window, and always carries `rspData`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request beat offered |
| reqReady | output | 1 | Slave can take a request |
| reqAddr | input | 32 | Byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Access size code (not used by the slave) |
| reqWdata | input | 32 | Lane-aligned write data |
| reqStrb | input | 4 | Byte-lane write enables |
| reqAmo | input | 4 | Atomic-op code (ignored) |
| rspValid | output | 1 | Response beat offered |
| rspReady | input | 1 | Master takes the response |
| rspData | output | 32 | Read word, zero for writes and errors |
| rspErr | output | 1 | Slave-owned fault (address outside the window) |

## Verification
The only internal state is the pending-response flag, the captured word select and error, and the RAM. Each one shows at the ports within one response.

- A pending flag that is stuck or cleared early shows up as one of three faults. `reqReady` may rise while a response waits. A response may vanish during a stall. A second request may be taken before the first retires.
- A wrong word-select or error capture corrupts `rspData` or `rspErr` on the very next response.
- RAM damage from a bad strobe merge, or from a write outside the window, appears on the first read of the affected word. The bench reads such words back right after each suspect write.

// File: rtl/memslv_pkg.sv
package memslv_pkg;

  // Strobes issued by the control unit to the datapath for one cycle.
  typedef struct packed {
    logic accept;  // a request beat transfers at this edge
    logic wrEn;    // in-window write: update RAM lanes
    logic rdEn;    // in-window read: fetch RAM row
  } ctrlStrobes_t;

endpackage

// File: rtl/memslv_ctrl.sv
module memslv_ctrl
  import memslv_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         winHit,
  input  logic         rspReady,
  output logic         reqReady,
  output logic         rspValid,
  output ctrlStrobes_t strobes
);

  logic pendingQ;

  // One transaction in flight: requests are refused while a response waits.
  assign reqReady = !pendingQ;
  assign rspValid = pendingQ;

  always_comb begin
    strobes.accept = reqValid && reqReady;
    strobes.wrEn   = strobes.accept && reqWrite && winHit;
    strobes.rdEn   = strobes.accept && !reqWrite && winHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
    end else if (strobes.accept) begin
      pendingQ <= 1'b1;
    end else if (pendingQ && rspReady) begin
      pendingQ <= 1'b0;
    end
  end

endmodule

// File: rtl/memslv_dpath.sv
module memslv_dpath
  import memslv_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR     = 32'h8000_0000,
  parameter int          WINDOW_BYTES  = 65536,
  parameter int          WORDS_PER_ROW = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [31:0]  reqAddr,
  input  logic [31:0]  reqWdata,
  input  logic [3:0]   reqStrb,
  input  ctrlStrobes_t strobes,
  output logic         winHit,
  output logic [31:0]  rspData,
  output logic         rspErr
);

  localparam int WIN_BITS   = $clog2(WINDOW_BYTES);
  localparam int WORD_BITS  = WIN_BITS - 2;
  localparam int SEL_BITS   = $clog2(WORDS_PER_ROW);
  localparam int ROW_BITS   = WORD_BITS - SEL_BITS;
  localparam int ROWS       = 1 << ROW_BITS;
  localparam int ROW_WIDTH  = 32 * WORDS_PER_ROW;
  localparam logic [31:0] WIN_MASK = ~(32'(WINDOW_BYTES) - 32'd1);

  // Window decode on the upper address bits only.
  assign winHit = ((reqAddr & WIN_MASK) == (BASE_ADDR & WIN_MASK));

  logic [WORD_BITS-1:0] wordIdx;
  logic [ROW_BITS-1:0]  rowIdx;
  logic [SEL_BITS-1:0]  selIdx;

  assign wordIdx = reqAddr[2 +: WORD_BITS];
  assign rowIdx  = wordIdx[WORD_BITS-1:SEL_BITS];
  assign selIdx  = wordIdx[SEL_BITS-1:0];

  // Wide-row storage: each row packs several words.
  logic [ROW_WIDTH-1:0] ramQ [ROWS];
  logic [ROW_WIDTH-1:0] rowQ;

  always_ff @(posedge clk) begin
    if (strobes.wrEn) begin
      for (int lane = 0; lane < 4; lane++) begin
        if (reqStrb[lane]) begin
          ramQ[rowIdx][32*selIdx + 8*lane +: 8] <= reqWdata[8*lane +: 8];
        end
      end
    end
    if (strobes.rdEn) begin
      rowQ <= ramQ[rowIdx];
    end
  end

  // Response capture: held until the next accepted request.
  logic [SEL_BITS-1:0] selQ;
  logic                readQ;
  logic                errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      readQ <= 1'b0;
      errQ  <= 1'b0;
    end else if (strobes.accept) begin
      selQ  <= selIdx;
      readQ <= strobes.rdEn;
      errQ  <= !winHit;
    end
  end

  assign rspData = readQ ? rowQ[32*selQ +: 32] : 32'd0;
  assign rspErr  = errQ;

endmodule

// File: rtl/memslv_top.sv
module memslv_top
  import memslv_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR     = 32'h8000_0000,
  parameter int          WINDOW_BYTES  = 65536,
  parameter int          WORDS_PER_ROW = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqAddr,
  input  logic        reqWrite,
  input  logic [1:0]  reqSize,
  input  logic [31:0] reqWdata,
  input  logic [3:0]  reqStrb,
  input  logic [3:0]  reqAmo,
  output logic        rspValid,
  input  logic        rspReady,
  output logic [31:0] rspData,
  output logic        rspErr
);

  ctrlStrobes_t strobes;
  logic         winHit;

  // Size, atomic code and the byte offset are the master's business.
  logic unusedReqBits;
  assign unusedReqBits = ^{reqSize, reqAmo, reqAddr[1:0]};

  memslv_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .winHit   (winHit),
    .rspReady (rspReady),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobes  (strobes)
  );

  memslv_dpath #(
    .BASE_ADDR     (BASE_ADDR),
    .WINDOW_BYTES  (WINDOW_BYTES),
    .WORDS_PER_ROW (WORDS_PER_ROW)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqStrb  (reqStrb),
    .strobes  (strobes),
    .winHit   (winHit),
    .rspData  (rspData),
    .rspErr   (rspErr)
  );

endmodule

// File: rtl/memslv_checker.sv
module memslv_checker #(
  parameter logic [31:0] BASE_ADDR    = 32'h8000_0000,
  parameter int          WINDOW_BYTES = 65536
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqAddr,
  input logic        reqWrite,
  input logic        rspValid,
  input logic        rspReady,
  input logic [31:0] rspData,
  input logic        rspErr
);

  logic inWin;
  assign inWin = (reqAddr >= BASE_ADDR) &&
                 ({1'b0, reqAddr} < ({1'b0, BASE_ADDR} + 33'(WINDOW_BYTES)));

  p_busy_blocks_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  p_hold_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData) && $stable(rspErr)));

  p_outside_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !inWin) |=> (rspErr && rspData == 32'd0));

  p_inside_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && inWin) |=> !rspErr);

  p_write_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> (rspData == 32'd0));

endmodule

bind memslv_top memslv_checker #(
  .BASE_ADDR    (BASE_ADDR),
  .WINDOW_BYTES (WINDOW_BYTES)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqAddr  (reqAddr),
  .reqWrite (reqWrite),
  .rspValid (rspValid),
  .rspReady (rspReady),
  .rspData  (rspData),
  .rspErr   (rspErr)
);

// File: tb/memslv_top_test.sv
`timescale 1ns/1ps
module memslv_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'b10;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqStrb = '0;
  logic [3:0]  reqAmo = '0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic [31:0] rspData;
  logic        rspErr;

  always #10 clk = ~clk;

  memslv_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqWdata(reqWdata), .reqStrb(reqStrb), .reqAmo(reqAmo),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData),
    .rspErr(rspErr)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int stallMode = 0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  logic [31:0] model [int];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit inWindow(input logic [31:0] a);
    return a >= 32'h8000_0000 && a <= 32'h8000_FFFF;
  endfunction

  // Driver: issues one request, predicts its response and pushes it.
  task automatic doReq(input logic [31:0] a, input logic w, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [3:0] st,
                       input logic [3:0] amo, input string tag);
    expItem_t it;
    int key;
    @(negedge clk);
    reqAddr = a; reqWrite = w; reqSize = sz; reqWdata = wd;
    reqStrb = st; reqAmo = amo; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    key = int'(a[15:2]);
    it.tag = tag;
    if (!inWindow(a)) begin
      it.err = 1'b1; it.data = 32'd0;
    end else if (w) begin
      logic [31:0] cur;
      cur = model.exists(key) ? model[key] : 32'd0;
      for (int l = 0; l < 4; l++)
        if (st[l]) cur[8*l +: 8] = wd[8*l +: 8];
      model[key] = cur;
      it.err = 1'b0; it.data = 32'd0;
    end else begin
      it.err = 1'b0;
      it.data = model.exists(key) ? model[key] : 32'd0;
    end
    expQ.push_back(it);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid === 1'b1, {tag, " R2 rspValid after accept"}, 32'(rspValid), 32'd1);
    check(reqReady === 1'b0, {tag, " R1 reqReady low while pending"}, 32'(reqReady), 32'd0);
  endtask

  // Monitor: drives rspReady, compares retiring responses, checks stall hold.
  initial begin : monitor
    logic        pValid = 1'b0;
    logic        pReady = 1'b1;
    logic [31:0] pData = '0;
    logic        pErr = 1'b0;
    int          cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rstN) begin
        if (pValid && !pReady) begin
          check(rspValid === 1'b1 && rspData === pData && rspErr === pErr,
                "R3 response held during stall", rspData, pData);
        end
        rspReady = (stallMode == 0) ? 1'b1 : ((cyc % 4) == 0);
        if (rspValid && rspReady) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R1 unexpected response", rspData, 32'd0);
          end else begin
            expItem_t it;
            it = expQ.pop_front();
            check(rspData === it.data, {it.tag, " data"}, rspData, it.data);
            check(rspErr === it.err, {it.tag, " err"}, 32'(rspErr), 32'(it.err));
          end
        end
        pValid = rspValid; pReady = rspReady; pData = rspData; pErr = rspErr;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    // R9: reset state
    check(rspValid === 1'b0, "R9 rspValid in reset", 32'(rspValid), 32'd0);
    check(reqReady === 1'b1, "R9 reqReady in reset", 32'(reqReady), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid === 1'b0, "R9 rspValid after reset", 32'(rspValid), 32'd0);

    // R1: no request offered, no response
    repeat (5) @(negedge clk);
    check(rspValid === 1'b0, "R1 idle without reqValid", 32'(rspValid), 32'd0);

    // R4/R10/R2: full word, byte lane, halfword
    doReq(32'h8000_0000, 1, 2'b10, 32'h1122_3344, 4'hF, 4'h0, "R10 write word");
    doReq(32'h8000_0000, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R2 read word");
    doReq(32'h8000_0001, 1, 2'b00, 32'h0000_AB00, 4'b0010, 4'h0, "R4 byte write");
    doReq(32'h8000_0000, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R4 byte lane readback");
    doReq(32'h8000_0002, 1, 2'b01, 32'hBEEF_0000, 4'b1100, 4'h0, "R4 half write");
    doReq(32'h8000_0000, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R4 half readback");
    doReq(32'h8000_0024, 1, 2'b10, 32'hCAFE_F00D, 4'hF, 4'h0, "R4 other word");
    doReq(32'h8000_0024, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R4 other word readback");

    // R5/R6: window edges and aliasing
    doReq(32'h8000_FFFC, 1, 2'b10, 32'h5A5A_A5A5, 4'hF, 4'h0, "R5 last word write");
    doReq(32'h8000_FFFC, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R5 last word read");
    doReq(32'h7FFF_FFFC, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R5 below window read");
    doReq(32'h8001_0000, 1, 2'b10, 32'hDEAD_DEAD, 4'hF, 4'h0, "R6 outside write");
    doReq(32'h8000_0000, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R6 alias word unchanged");
    doReq(32'h8001_FFFC, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R6 outside read");

    // R7: misaligned / odd size in window
    doReq(32'h8000_0003, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R7 misaligned word read");
    doReq(32'h8000_0026, 0, 2'b00, 32'h0, 4'h0, 4'h0, "R7 byte size read");
    doReq(32'h8000_0005, 1, 2'b10, 32'h7777_8888, 4'hF, 4'h0, "R7 misaligned write");
    doReq(32'h8000_0004, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R7 misaligned write readback");

    // R8: atomic code ignored
    doReq(32'h8000_0040, 1, 2'b10, 32'h0BAD_C0DE, 4'hF, 4'h9, "R8 write amo set");
    doReq(32'h8000_0040, 0, 2'b10, 32'h0, 4'h0, 4'hF, "R8 read amo set");

    // R3: back-pressure on the response channel
    stallMode = 1;
    doReq(32'h8000_0000, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R3 stalled read a");
    doReq(32'h8000_FFFC, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R3 stalled read b");
    doReq(32'h8001_0004, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R3 stalled error");
    doReq(32'h8000_0024, 1, 2'b10, 32'h1234_5678, 4'b0101, 4'h0, "R3 stalled write");
    doReq(32'h8000_0024, 0, 2'b10, 32'h0, 4'h0, 4'h0, "R3 stalled readback");

    // drain
    for (int i = 0; i < 50 && expQ.size() != 0; i++) @(negedge clk);
    check(expQ.size() == 0, "R2 all responses returned", 32'(expQ.size()), 32'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule